// File: doc/BRIEF.md
# Parallel ADC Result Port with Sync Settling

This block sits between the decimation filter of a sigma-delta converter and a 16-bit parallel host bus. It runs its own word-period counter on the master clock. At each word boundary it takes the filter's current result, puts it on the output register and drops an active-high not-ready flag to mark the word as valid. Shortly before each boundary the flag rises for a fixed number of clocks. A two-bit mode input selects the filter type and the decimation ratio together, and the ratio sets the word period.

A synchronisation input and any change of the mode input restart the filter. While sync is high, and for a settling count after it falls, the not-ready flag stays high and incoming results are dropped. The host reads through active-low chip-select and read strobes. These are registered and drive an output-enable that controls the bus tristate buffers. With both strobes held low, the bus follows every new word.

Top module: `pbus_adc_rdif`

## Requirements
- R1: `mode_sel` encodes the operating mode. 2'b01 is band-pass with a word every 32 clocks. 2'b10 is low-pass with a word every 32 clocks. 2'b11 is low-pass with a word every 16 clocks. 2'b00 means the parallel port is inactive: `data_oe` is low one clock after 2'b00 is applied, and `not_rdy` stays high.
- R2: In steady operation, `not_rdy` falls exactly once every 32 clocks in modes 01 and 10, and exactly once every 16 clocks in mode 11.
- R3: Before each new word, `not_rdy` is high for exactly 2 clocks. It falls on the same clock edge on which the new word appears on `data_out`.
- R4: `data_out` changes only on an edge where `not_rdy` falls. It then holds the `word_in` value present at that edge.
- R5: `data_oe` goes high one clock after `cs_n` and `rd_n` are both low in an active mode. It goes low one clock after either strobe goes high. With both strobes held low, `data_oe` stays high while `data_out` updates with every word.
- R6: `sync_in` is registered on the rising clock. Two clock edges after `sync_in` is seen high, `not_rdy` is high.
- R7: After the edge that first registers `sync_in` low, `not_rdy` first falls S+P edges later. S is 1293 and P is 32 in modes 01 and 10. S is 541 and P is 16 in mode 11.
- R8: While `sync_in` is high and during settling, `not_rdy` stays high and `data_out` holds its last value, whatever `word_in` does.
- R9: A change of `mode_sel` acts as a sync pulse of one clock. The first word in the new mode follows R7 with the new mode's S and P.
- R10: If `word_vld` is low at a word boundary, no word is taken. `data_out` holds and `not_rdy` stays high until a boundary where `word_vld` is high.
- R11: During reset, `not_rdy` is 1, `data_oe` is 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Filter type and decimation ratio |
| sync_in | input | 1 | Filter restart request |
| word_vld | input | 1 | Filter result valid (models the filter) |
| word_in | input | 16 | Filter result |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_out | output | 16 | Result word presented to the bus drivers |
| data_oe | output | 1 | Bus driver enable; low means high impedance |
| not_rdy | output | 1 | High while no fresh valid word is available |

## Verification
The hardest case to reach is the exact first-word latency after a restart. It depends on the settling count, the realignment of the word-period counter, and the register on the sync input. The bench starts each table row with a multi-cycle sync pulse, or with a bare mode change. It then counts clocks to the first falling edge of `not_rdy` and compares the count with S+P. During the wait it changes `word_in` and checks that `data_out` does not move, and it drops `word_vld` at a boundary to reach the skipped-word path.

// File: rtl/pbrd_pkg.sv
package pbrd_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_BP32 = 2'b01,
        MODE_LP32 = 2'b10,
        MODE_LP16 = 2'b11
    } mode_e;
endpackage

// File: rtl/pbrd_mode_dec.sv
// Decodes the mode pins into port activity, word period and settling count.
module pbrd_mode_dec #(
    parameter int PERIOD_LONG  = 32,
    parameter int PERIOD_SHORT = 16,
    parameter int SETTLE_LONG  = 1293,
    parameter int SETTLE_SHORT = 541,
    parameter int PHW          = 5,
    parameter int SW           = 11
) (
    input  logic [1:0]     mode_sel,
    output logic           active,
    output logic [PHW-1:0] period_m1,
    output logic [SW-1:0]  settle_v
);
    import pbrd_pkg::*;

    always_comb begin
        active    = 1'b1;
        period_m1 = PHW'(PERIOD_LONG - 1);
        settle_v  = SW'(SETTLE_LONG);
        unique case (mode_e'(mode_sel))
            MODE_OFF:  active = 1'b0;
            MODE_BP32,
            MODE_LP32: ;
            MODE_LP16: begin
                period_m1 = PHW'(PERIOD_SHORT - 1);
                settle_v  = SW'(SETTLE_SHORT);
            end
            default:   active = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbrd_bus_drv.sv
// Output word register and registered bus enable.
module pbrd_bus_drv #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          oe
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          oe;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d      = bus_q;
        bus_d.oe   = active && !cs_n && !rd_n;
        if (load) begin
            bus_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign dout = bus_q.data;
    assign oe   = bus_q.oe;
endmodule

// File: rtl/pbus_adc_rdif.sv
// Parallel result port: word timing, ready flag, sync settling, bus control.
module pbus_adc_rdif #(
    parameter int DW           = 16,
    parameter int PERIOD_LONG  = 32,
    parameter int PERIOD_SHORT = 16,
    parameter int SETTLE_LONG  = 1293,
    parameter int SETTLE_SHORT = 541,
    parameter int PULSE        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          sync_in,
    input  logic          word_vld,
    input  logic [DW-1:0] word_in,
    input  logic          cs_n,
    input  logic          rd_n,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          not_rdy
);
    localparam int PHW = $clog2(PERIOD_LONG);
    localparam int SW  = $clog2(SETTLE_LONG + 1);

    typedef struct packed {
        logic           sync;
        logic [1:0]     mode;
        logic [SW-1:0]  settle;
        logic [PHW-1:0] phase;
        logic           rdy_n;
    } st_t;

    st_t st_d, st_q;

    logic           active;
    logic [PHW-1:0] period_m1;
    logic [SW-1:0]  settle_v;
    logic [PHW-1:0] hi_start;
    logic [PHW-1:0] nxt_phase;
    logic           restart;
    logic           load;

    pbrd_mode_dec #(
        .PERIOD_LONG (PERIOD_LONG),
        .PERIOD_SHORT(PERIOD_SHORT),
        .SETTLE_LONG (SETTLE_LONG),
        .SETTLE_SHORT(SETTLE_SHORT),
        .PHW         (PHW),
        .SW          (SW)
    ) u_dec (
        .mode_sel (mode_sel),
        .active   (active),
        .period_m1(period_m1),
        .settle_v (settle_v)
    );

    assign hi_start  = period_m1 - PHW'(PULSE - 1);
    assign nxt_phase = st_q.phase + 1'b1;
    assign restart   = st_q.sync || (mode_sel != st_q.mode) || !active;

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_in;
        st_d.mode = mode_sel;
        load      = 1'b0;
        if (restart) begin
            st_d.settle = settle_v;
            st_d.phase  = '0;
            st_d.rdy_n  = 1'b1;
        end else if (st_q.settle != '0) begin
            st_d.settle = st_q.settle - 1'b1;
            st_d.phase  = '0;
            st_d.rdy_n  = 1'b1;
        end else if (st_q.phase == period_m1) begin
            st_d.phase = '0;
            st_d.rdy_n = !word_vld;
            load       = word_vld;
        end else begin
            st_d.phase = nxt_phase;
            if (nxt_phase >= hi_start) begin
                st_d.rdy_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rdy_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    pbrd_bus_drv #(.DW(DW)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .active(active),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .load  (load),
        .din   (word_in),
        .dout  (data_out),
        .oe    (data_oe)
    );

    assign not_rdy = st_q.rdy_n;
endmodule

// File: rtl/pbus_adc_rdif_chk.sv
module pbus_adc_rdif_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_sel,
    input logic          sync_in,
    input logic          word_vld,
    input logic          cs_n,
    input logic          rd_n,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic          not_rdy
);
    assert_sync_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |-> ##2 not_rdy);

    assert_oe_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!cs_n && !rd_n));

    assert_data_only_on_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> $fell(not_rdy));

    assert_fall_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(not_rdy) |-> $past(word_vld));

    assert_off_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> !data_oe);
endmodule

bind pbus_adc_rdif pbus_adc_rdif_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .sync_in (sync_in),
    .word_vld(word_vld),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .data_out(data_out),
    .data_oe (data_oe),
    .not_rdy (not_rdy)
);

// File: tb/pbus_adc_rdif_test.sv
module pbus_adc_rdif_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_sel;
    logic        sync_in;
    logic        word_vld;
    logic [15:0] word_in;
    logic        cs_n;
    logic        rd_n;
    logic [15:0] data_out;
    logic        data_oe;
    logic        not_rdy;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pbus_adc_rdif uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sync_in(sync_in),
        .word_vld(word_vld), .word_in(word_in), .cs_n(cs_n), .rd_n(rd_n),
        .data_out(data_out), .data_oe(data_oe), .not_rdy(not_rdy)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [15:0] w;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'b10, 16'h1234},
        '{2'b01, 16'hBEEF},
        '{2'b11, 16'h0001},
        '{2'b11, 16'hFFFF},
        '{2'b10, 16'h8000},
        '{2'b01, 16'h7FFE}
    };

    function automatic int per_of(logic [1:0] m);
        return (m == 2'b11) ? 16 : 32;
    endfunction

    function automatic int set_of(logic [1:0] m);
        return (m == 2'b11) ? 541 : 1293;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Counts negedges until not_rdy goes from 1 to 0; hi counts high samples.
    task automatic wait_fall(input int maxc, output int n, output int hi);
        logic prev;
        prev = not_rdy;
        n  = 0;
        hi = 0;
        while (n < maxc) begin
            @(negedge clk);
            n++;
            if (prev === 1'b1 && not_rdy === 1'b0) break;
            if (not_rdy === 1'b1) hi++;
            prev = not_rdy;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, hi;
        logic [15:0] held;
        bit moved;
        rst_n = 1'b0; mode_sel = 2'b10; sync_in = 1'b0; word_vld = 1'b1;
        word_in = 16'hAAAA; cs_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(not_rdy === 1'b1, "R11", "not_rdy in reset", int'(not_rdy), 1);
        chk(data_oe === 1'b0, "R11", "data_oe in reset", int'(data_oe), 0);
        chk(data_out === 16'h0, "R11", "data_out in reset", int'(data_out), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_sel = VEC[i].m; word_in = VEC[i].w; word_vld = 1'b1; sync_in = 1'b1;
            repeat (3) @(negedge clk);
            sync_in = 1'b0;
            wait_fall(3000, n, hi);
            // R7: first fall S+P edges after the edge that first registers sync low
            chk(n == set_of(VEC[i].m) + per_of(VEC[i].m) + 1, "R7", "first word latency",
                n, set_of(VEC[i].m) + per_of(VEC[i].m) + 1);
            chk(data_out === VEC[i].w, "R4", "first word", int'(data_out), int'(VEC[i].w));
            chk(data_oe === 1'b1, "R5", "oe with strobes low", int'(data_oe), 1);
            word_in = ~VEC[i].w;
            wait_fall(100, n, hi);
            chk(n == per_of(VEC[i].m), "R2", "word period", n, per_of(VEC[i].m));
            chk(hi == 2, "R3", "ready pulse width", hi, 2);
            chk(data_out === ~VEC[i].w, "R5", "bus follows word", int'(data_out),
                int'(~VEC[i].w));
        end

        // R5: strobes control the enable with one clock of latency
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        chk(data_oe === 1'b0, "R5", "oe after cs high", int'(data_oe), 0);
        cs_n = 1'b0;
        @(negedge clk);
        chk(data_oe === 1'b1, "R5", "oe after cs low", int'(data_oe), 1);
        rd_n = 1'b1;
        @(negedge clk);
        chk(data_oe === 1'b0, "R5", "oe after rd high", int'(data_oe), 0);
        rd_n = 1'b0;

        // R10: invalid word at a boundary is skipped
        wait_fall(100, n, hi);
        held = data_out;
        word_vld = 1'b0; word_in = 16'h5A5A;
        repeat (80) @(negedge clk);
        chk(not_rdy === 1'b1, "R10", "ready held without valid", int'(not_rdy), 1);
        chk(data_out === held, "R10", "data held without valid", int'(data_out), int'(held));
        word_vld = 1'b1;
        wait_fall(100, n, hi);
        chk(n >= 1 && n <= 32, "R10", "word after valid returns", n, 32);
        chk(data_out === 16'h5A5A, "R10", "resumed word", int'(data_out), 16'h5A5A);

        // R6 and R8: sync forces ready high and freezes the bus
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(not_rdy === 1'b1, "R6", "ready after sync", int'(not_rdy), 1);
        word_in = 16'hC3C3; sync_in = 1'b0;
        moved = 1'b0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (not_rdy !== 1'b1 || data_out !== 16'h5A5A) moved = 1'b1;
        end
        chk(!moved, "R8", "bus frozen while settling", int'(data_out), 16'h5A5A);
        wait_fall(2000, n, hi);
        chk(data_out === 16'hC3C3, "R8", "word after settle", int'(data_out), 16'hC3C3);

        // R9: mode change restarts settling with the new mode's counts
        @(negedge clk); mode_sel = 2'b11; word_in = 16'h0F0F;
        wait_fall(2000, n, hi);
        chk(n == 541 + 16 + 1, "R9", "latency after mode change", n, 541 + 16 + 1);
        chk(data_out === 16'h0F0F, "R9", "word after mode change", int'(data_out), 16'h0F0F);

        // R1: mode 00 releases the bus and keeps ready high
        @(negedge clk); mode_sel = 2'b00;
        @(negedge clk);
        chk(data_oe === 1'b0, "R1", "oe in off mode", int'(data_oe), 0);
        moved = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (not_rdy !== 1'b1 || data_oe !== 1'b0) moved = 1'b1;
        end
        chk(!moved, "R1", "off mode stays idle", int'(not_rdy), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule